// File: doc/BRIEF.md
# Control/Data Command Word Parser

This block sits behind an I2C slave byte receiver and converts the bytes of a write transfer into single-byte writes toward a display controller. After a START, the first byte names the target address and the transfer direction. If the transfer is a write to this block's own address, the bytes that follow are read as command words. Each command word is a control byte followed by a payload byte.

The control byte carries two flags. The continuation flag says whether another control byte will follow. The select flag says whether the payload is display memory data or a command. While continuation is set, control bytes and payload bytes alternate. When a control byte with continuation cleared arrives, the select value is held. Every byte after it, up to the next START or STOP, is issued as a payload with that held value. Control bytes never produce a write. Each payload byte produces a one-cycle strobe with the byte and its select flag. Decoding of the commands is left to the logic downstream.

Top module: `cwp_parser`

## Requirements
- R1: After reset, wr_strobe is 0 and the parser is idle. Bytes that arrive before the first START produce no strobe.
- R2: The first byte after a START is the address byte. Bits 7..1 hold the address and bit 0 holds the direction, where 0 means write. Only a write to SLAVE_ADDR enables parsing.
- R3: In a selected write, the next byte is a control byte. Bit 7 is the continuation flag and bit 6 is the select flag, where 1 means display data and 0 means command. Bits 5..0 have no effect, and a control byte produces no strobe.
- R4: After a control byte with bit 7 = 1, exactly the next byte is issued as a payload with that control byte's select flag. The byte after that is again a control byte.
- R5: After a control byte with bit 7 = 0, every later byte is issued as a payload with the held select flag, until the next START or STOP.
- R6: A payload byte accepted on a clock edge raises wr_strobe for the following cycle only, with wr_payload equal to the byte and wr_is_data equal to the select flag.
- R7: A START (including a repeated START) returns the parser to expect an address byte. Any half-finished command word is dropped.
- R8: A STOP returns the parser to idle. Later bytes produce no strobe until the next START.
- R9: If the address byte is a read, or names another address, no byte of that transfer produces a strobe.
- R10: A byte presented in the same cycle as START or STOP is dropped. If START and STOP are both high, START wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| byte_valid | input | 1 | One-cycle pulse: byte_data holds an acknowledged byte |
| byte_data | input | 8 | Received byte |
| wr_strobe | output | 1 | One-cycle write strobe for a payload byte |
| wr_payload | output | 8 | Payload byte, valid with wr_strobe |
| wr_is_data | output | 1 | 1 = display data, 0 = command; valid with wr_strobe |

## Verification
The hardest case to reach from the ports is a command word cut off halfway. This happens when a control byte with continuation set has been taken and a repeated START or a same-cycle START arrives before its payload. The bench builds this case by interrupting alternating and streaming transfers at chosen points. It then checks that the next byte after the new address is treated as a control byte and not as a payload. Control bytes are swept over all low-bit patterns and both flag values, and a full 256-value stream is sent, so the select decoding is tested across the whole byte range.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CO_BIT = BYTE_W - 1;
  localparam int DC_BIT = BYTE_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_CTRL   = 3'd2,
    ST_DATA   = 3'd3,
    ST_STREAM = 3'd4,
    ST_SKIP   = 3'd5
  } cwp_state_e;

  function automatic logic addr_is_our_write(input logic [BYTE_W-1:0] b,
                                             input logic [ADDR_W-1:0] a);
    return (b[BYTE_W-1:1] == a) && !b[0];
  endfunction

  function automatic logic ctrl_continues(input logic [BYTE_W-1:0] b);
    return b[CO_BIT];
  endfunction

  function automatic logic ctrl_select(input logic [BYTE_W-1:0] b);
    return b[DC_BIT];
  endfunction
endpackage

// File: rtl/cwp_addr_filter.sv
module cwp_addr_filter
  import cwp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h3C
) (
  input  logic [BYTE_W-1:0] byte_data,
  output logic              addr_hit
);
  always_comb addr_hit = addr_is_our_write(byte_data, SLAVE_ADDR);
endmodule

// File: rtl/cwp_word_fsm.sv
module cwp_word_fsm
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              addr_hit,
  output cwp_state_e        state,
  output logic              emit,
  output logic              dc_held
);
  cwp_state_e state_nx;
  logic       dc_nx;

  // named events
  logic byte_ok, ev_addr, ev_ctrl, ev_pair_data, ev_stream_data;
  assign byte_ok        = byte_valid && !bus_start && !bus_stop;
  assign ev_addr        = byte_ok && (state == ST_ADDR);
  assign ev_ctrl        = byte_ok && (state == ST_CTRL);
  assign ev_pair_data   = byte_ok && (state == ST_DATA);
  assign ev_stream_data = byte_ok && (state == ST_STREAM);
  assign emit           = ev_pair_data || ev_stream_data;

  always_comb begin
    state_nx = state;
    dc_nx    = dc_held;
    if (bus_start) begin
      state_nx = ST_ADDR;
    end else if (bus_stop) begin
      state_nx = ST_IDLE;
    end else if (ev_addr) begin
      state_nx = addr_hit ? ST_CTRL : ST_SKIP;
    end else if (ev_ctrl) begin
      dc_nx    = ctrl_select(byte_data);
      state_nx = ctrl_continues(byte_data) ? ST_DATA : ST_STREAM;
    end else if (ev_pair_data) begin
      state_nx = ST_CTRL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dc_held <= 1'b0;
    end else begin
      state   <= state_nx;
      dc_held <= dc_nx;
    end
  end

  a_r7_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> state == ST_ADDR);
  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !bus_start) |=> state == ST_IDLE);
  a_r4_pair_back_to_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_data |=> state == ST_CTRL);
  a_r9_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP && !bus_start && !bus_stop) |=> state == ST_SKIP);
  a_r5_stream_dc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM && !bus_start && !bus_stop) |=> (state == ST_STREAM) && $stable(dc_held));
  a_r1_idle_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_ADDR) |-> !emit);
endmodule

// File: rtl/cwp_out_reg.sv
module cwp_out_reg
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              dc_sel,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_payload,
  output logic              wr_is_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe  <= 1'b0;
      wr_payload <= '0;
      wr_is_data <= 1'b0;
    end else begin
      wr_strobe <= emit;
      if (emit) begin
        wr_payload <= byte_data;
        wr_is_data <= dc_sel;
      end
    end
  end
endmodule

// File: rtl/cwp_parser.sv
module cwp_parser
  import cwp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_payload,
  output logic              wr_is_data
);
  logic       addr_hit;
  cwp_state_e state;
  logic       emit;
  logic       dc_held;
  logic       dc_for_emit;

  cwp_addr_filter #(.SLAVE_ADDR(SLAVE_ADDR)) u_filt (
    .byte_data(byte_data), .addr_hit(addr_hit));

  cwp_word_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .addr_hit(addr_hit),
    .state(state), .emit(emit), .dc_held(dc_held));

  assign dc_for_emit = dc_held;

  cwp_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .dc_sel(dc_for_emit),
    .byte_data(byte_data), .wr_strobe(wr_strobe), .wr_payload(wr_payload),
    .wr_is_data(wr_is_data));

  logic plain_byte;
  assign plain_byte = byte_valid && !bus_start && !bus_stop;

  a_r3_ctrl_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_byte && state == ST_CTRL) |=> !wr_strobe);
  a_r5_stream_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_byte && state == ST_STREAM) |=> wr_strobe && (wr_payload == $past(byte_data)));
  a_r10_event_drops_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && (bus_start || bus_stop)) |=> !wr_strobe);
  a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> !wr_strobe);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !wr_strobe);
endmodule

// File: tb/cwp_parser_tb_top.sv
module cwp_parser_tb_top;
  localparam logic [6:0] ADDR = 7'h3C;
  logic clk = 0, rst_n = 0;
  logic bus_start = 0, bus_stop = 0, byte_valid = 0;
  logic [7:0] byte_data = 0;
  logic wr_strobe, wr_is_data;
  logic [7:0] wr_payload;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cwp_parser #(.SLAVE_ADDR(ADDR)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit sel_of(input logic [7:0] c);
    return ((c >> 6) % 2) == 1;
  endfunction

  // send one byte, check the output one cycle later
  task automatic put(input logic [7:0] b, input bit exp_s, input bit exp_dc, input string req,
                     input bit st = 0, input bit sp = 0);
    @(negedge clk);
    byte_valid = 1; byte_data = b; bus_start = st; bus_stop = sp;
    @(negedge clk);
    byte_valid = 0; bus_start = 0; bus_stop = 0;
    chk(wr_strobe == exp_s, req, wr_strobe, exp_s);
    if (exp_s) begin
      chk(wr_payload == b, req, wr_payload, b);
      chk(wr_is_data == exp_dc, req, wr_is_data, exp_dc);
    end
  endtask

  task automatic pulse(input bit st, input bit sp);
    @(negedge clk);
    bus_start = st; bus_stop = sp;
    @(negedge clk);
    bus_start = 0; bus_stop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_strobe == 0, "R1 reset", wr_strobe, 0);
    rst_n = 1;
    put(8'h80, 0, 0, "R1 pre-start");
    put(8'h55, 0, 0, "R1 pre-start");

    // R2/R3/R4: alternating pairs, sweep low bits and select
    pulse(1, 0);
    put({ADDR, 1'b0}, 0, 0, "R2 addr");
    for (int i = 0; i < 128; i++) begin
      logic [7:0] c;
      c = {1'b1, i[6], i[5:0]};
      put(c, 0, 0, "R3 ctrl silent");
      put(8'((i * 37 + 11) % 256), 1, sel_of(c), "R4 pair payload");
    end
    // R6 single-cycle strobe
    @(negedge clk);
    chk(wr_strobe == 0, "R6 one cycle", wr_strobe, 0);

    // R5: last control, stream all 256 values
    put(8'h7F, 0, 0, "R3 last ctrl");
    for (int v = 0; v < 256; v++) put(8'(v), 1, 1, "R5 stream dc1");
    pulse(0, 1);
    put(8'hA5, 0, 0, "R8 after stop");

    // R5 with dc 0
    pulse(1, 0);
    put({ADDR, 1'b0}, 0, 0, "R2 addr");
    put(8'h3F, 0, 0, "R3 last ctrl dc0");
    for (int v = 0; v < 8; v++) put(8'(v * 29), 1, 0, "R5 stream dc0");

    // R9: read and foreign address
    pulse(1, 0);
    put({ADDR, 1'b1}, 0, 0, "R9 read addr");
    put(8'h00, 0, 0, "R9 read byte");
    put(8'h12, 0, 0, "R9 read byte");
    pulse(1, 0);
    put({ADDR ^ 7'h01, 1'b0}, 0, 0, "R9 other addr");
    put(8'h40, 0, 0, "R9 other byte");
    put(8'h99, 0, 0, "R9 other byte");
    pulse(0, 1);

    // R7: half word dropped by repeated start
    pulse(1, 0);
    put({ADDR, 1'b0}, 0, 0, "R2 addr");
    put(8'hC0, 0, 0, "R7 ctrl before cut");
    pulse(1, 0);
    put({ADDR, 1'b0}, 0, 0, "R7 readdr");
    put(8'h80, 0, 0, "R7 treated as ctrl");
    put(8'h6B, 1, 0, "R7 new word");

    // R10: byte with start dropped, start wins over stop
    put(8'h00, 0, 0, "R3 last ctrl");
    put(8'h21, 1, 0, "R5 stream");
    put(8'h44, 0, 0, "R10 byte with start", 1, 1);
    put({ADDR, 1'b0}, 0, 0, "R10 next is addr");
    put(8'h40, 0, 0, "R10 ctrl");
    put(8'h17, 1, 1, "R10 payload after");
    put(8'h18, 0, 0, "R10 byte with stop", 0, 1);
    put(8'h19, 0, 0, "R8 idle after stop");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule